// File: doc/BRIEF.md
# Ring Path Allocator for a 4x4 Memory Coupling Switch

This controller decides which processor-side requests may pass through a 4x4 circuit-switched coupling unit. Each of four processor ports can open an access to any of four memory ports. Four switching elements sit on a ring, and ring segment k joins element k to element (k+1) mod 4. A path from processor port s to memory port d runs clockwise over segments s, s+1, ... d-1 by default. When that route touches a segment marked faulty, the path runs counter-clockwise over the complementary, disjoint set of segments instead.

A segment's setting is the direction it carries. The controller keeps a live direction and a use count for every segment. A request is admitted only if its memory port is free and every segment on its route is either idle or already set in the same direction. Compatible paths can therefore share segments. An admitted path stays in place until the requester signals completion. The segment counts then drop, and a segment goes idle when its count reaches zero. Requests that cannot be admitted are retried on every cycle.

Top module: `path_alloc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every output is zero.
- R2: A request from an idle port with all of its resources free is granted on the next clock edge. The clockwise route lights exactly segments s through d-1 mod 4 with direction bit 0, and `p_alt` stays 0.
- R3: The destination memory port is the top two address bits `p_addr[32*s+31:32*s+30]`. While port s is granted, `m_busy[d]` is 1 and `m_src[2d+1:2d]` equals s.
- R4: A memory port serves one path at a time. A request to a busy memory port waits, and it is granted on the second edge after the holder's completion pulse.
- R5: Paths with the same direction may share segments. A shared segment stays active until the last path using it is released.
- R6: A request whose route needs a segment that is active in the opposite direction waits until that segment goes idle.
- R7: Requests presented on the same edge are evaluated in order from port 0 to port 3, and each later port sees the grants of the earlier ones.
- R8: If the clockwise route includes a segment flagged in `fault_seg`, the counter-clockwise route over segments s-1 down to d is used instead. In that case `p_alt` is 1 and `seg_dir` is 1 on those segments. A path with s equal to d uses no segment.
- R9: A completion pulse on a granted port releases its path on the next edge. A completion pulse on an ungranted port is ignored. `p_valid` and address changes on a granted port are also ignored.
- R10: If both routes contain a flagged segment, the request waits. It is granted once the flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_valid | input | 4 | Valid address present, one bit per processor port |
| p_addr | input | 4*ADDR_W | Address per processor port; the top two bits select the memory port |
| p_done | input | 4 | Access-complete pulse per processor port |
| fault_seg | input | 4 | Per-segment failure flags |
| p_grant | output | 4 | Path held for the processor port |
| p_alt | output | 4 | The held path uses the counter-clockwise route |
| m_busy | output | 4 | Memory port is connected |
| m_src | output | 8 | Processor index connected to each memory port, 2 bits per port |
| seg_active | output | 4 | Segment carries at least one path |
| seg_dir | output | 4 | Direction of each active segment (1 = counter-clockwise) |

## Verification
Several properties are checked on every cycle. The number of busy memory ports always equals the number of granted processor ports. No segment is active when nothing is granted. A grant never appears without a prior valid request, and a path never drops without a completion pulse. An active segment never flips direction. A newly activated segment was never flagged faulty on the edge that activated it. The exact route chosen for each source, destination and fault pattern can only be shown by the bench's sweeps. The same holds for the priority order, the wait-then-grant timing after a release, and the sharing and counting of segments.

// File: rtl/path_alloc_ctrl.sv
module path_alloc_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          p_valid,
  input  logic [4*ADDR_W-1:0] p_addr,
  input  logic [3:0]          p_done,
  input  logic [3:0]          fault_seg,
  output logic [3:0]          p_grant,
  output logic [3:0]          p_alt,
  output logic [3:0]          m_busy,
  output logic [7:0]          m_src,
  output logic [3:0]          seg_active,
  output logic [3:0]          seg_dir
);
  localparam int NP = 4;
  localparam int CNT_W = 3;

  logic [NP-1:0]    held_q, held_d, alt_q, alt_d, busy_q, busy_d, sdir_q, sdir_d;
  logic [1:0]       dst_q [NP];
  logic [1:0]       dst_d [NP];
  logic [NP-1:0]    mask_q [NP];
  logic [NP-1:0]    mask_d [NP];
  logic [CNT_W-1:0] cnt_q [NP];
  logic [CNT_W-1:0] cnt_d [NP];
  logic             unused_addr;

  assign unused_addr = ^p_addr;

  function automatic logic [3:0] ring_mask(input logic [1:0] s, input logic [1:0] d, input logic ccw);
    logic [3:0] m;
    logic [1:0] k;
    m = '0;
    for (int i = 0; i < 4; i++) begin
      k = 2'(i);
      if (!ccw) m[i] = (k - s) < (d - s);
      else      m[i] = (s - 2'd1 - k) < (s - d);
    end
    return m;
  endfunction

  always_comb begin
    logic [1:0] d;
    logic [3:0] prim, route;
    logic       use_alt, ok;
    held_d = held_q; alt_d = alt_q; busy_d = busy_q; sdir_d = sdir_q;
    for (int i = 0; i < NP; i++) begin
      dst_d[i] = dst_q[i]; mask_d[i] = mask_q[i]; cnt_d[i] = cnt_q[i];
    end
    for (int s = 0; s < NP; s++) begin
      d       = p_addr[s*ADDR_W + ADDR_W-1 -: 2];
      prim    = ring_mask(2'(s), d, 1'b0);
      use_alt = |(prim & fault_seg);
      route   = use_alt ? ring_mask(2'(s), d, 1'b1) : prim;
      ok      = p_valid[s] && !held_q[s] && !busy_d[d] && !(|(route & fault_seg));
      for (int k = 0; k < NP; k++)
        if (route[k] && cnt_d[k] != '0 && sdir_d[k] != use_alt) ok = 1'b0;
      if (ok) begin
        held_d[s] = 1'b1; alt_d[s] = use_alt; dst_d[s] = d; mask_d[s] = route;
        busy_d[d] = 1'b1;
        for (int k = 0; k < NP; k++)
          if (route[k]) begin
            cnt_d[k]  = cnt_d[k] + 1'b1;
            sdir_d[k] = use_alt;
          end
      end
    end
    for (int s = 0; s < NP; s++)
      if (held_q[s] && p_done[s]) begin
        held_d[s] = 1'b0;
        busy_d[dst_q[s]] = 1'b0;
        for (int k = 0; k < NP; k++)
          if (mask_q[s][k]) cnt_d[k] = cnt_d[k] - 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0; alt_q <= '0; busy_q <= '0; sdir_q <= '0;
      for (int i = 0; i < NP; i++) begin
        dst_q[i] <= '0; mask_q[i] <= '0; cnt_q[i] <= '0;
      end
    end else begin
      held_q <= held_d; alt_q <= alt_d; busy_q <= busy_d; sdir_q <= sdir_d;
      for (int i = 0; i < NP; i++) begin
        dst_q[i] <= dst_d[i]; mask_q[i] <= mask_d[i]; cnt_q[i] <= cnt_d[i];
      end
    end
  end

  always_comb begin
    m_src = '0;
    for (int s = 0; s < NP; s++)
      if (held_q[s]) m_src[2*dst_q[s] +: 2] = 2'(s);
  end

  assign p_grant = held_q;
  assign p_alt   = alt_q & held_q;
  assign m_busy  = busy_q;
  generate
    for (genvar k = 0; k < NP; k++) begin : g_seg
      assign seg_active[k] = cnt_q[k] != '0;
    end
  endgenerate
  assign seg_dir = sdir_q & seg_active;
endmodule

// File: rtl/path_alloc_ctrl_chk.sv
module path_alloc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] p_valid,
  input logic [3:0] p_done,
  input logic [3:0] fault_seg,
  input logic [3:0] p_grant,
  input logic [3:0] m_busy,
  input logic [3:0] seg_active,
  input logic [3:0] seg_dir
);
  p_busy_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(m_busy) == $countones(p_grant));

  p_idle_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (p_grant == 4'b0) |-> (seg_active == 4'b0 && m_busy == 4'b0));

  p_grant_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((p_grant & ~$past(p_grant) & ~$past(p_valid)) == 4'b0));

  p_hold_until_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~p_grant & $past(p_grant) & ~$past(p_done)) == 4'b0));

  p_dir_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_active & $past(seg_active) & (seg_dir ^ $past(seg_dir))) == 4'b0));

  p_no_faulty_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_active & ~$past(seg_active) & $past(fault_seg)) == 4'b0));
endmodule

bind path_alloc_ctrl path_alloc_ctrl_chk u_chk (.*);

// File: tb/test_path_alloc_ctrl.sv
module test_path_alloc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] p_valid = '0, p_done = '0, fault_seg = '0;
  logic [4*AW-1:0] p_addr = '0;
  logic [3:0] p_grant, p_alt, m_busy, seg_active, seg_dir;
  logic [7:0] m_src;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  path_alloc_ctrl #(.ADDR_W(AW)) i_path_alloc_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic req(input int s, input int d);
    p_addr[s*AW +: AW] = {2'(d), 30'(s*1000 + d*17 + 5)};
    p_valid[s] = 1'b1;
  endtask

  task automatic rel(input int s);
    p_valid[s] = 1'b0;
    p_done[s] = 1'b1;
    step();
    p_done[s] = 1'b0;
  endtask

  function automatic logic [3:0] exp_route(input int s, input int d, input bit ccw);
    logic [3:0] m = '0;
    int k = s;
    if (!ccw) begin
      for (int i = 0; i < ((d - s + 4) % 4); i++) begin m[k] = 1'b1; k = (k + 1) % 4; end
    end else begin
      for (int i = 0; i < ((s - d + 4) % 4); i++) begin k = (k + 3) % 4; m[k] = 1'b1; end
    end
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step();
    chk("R1 grant in reset", 32'(p_grant), 0);
    chk("R1 busy in reset", 32'(m_busy), 0);
    rst_n = 1'b1;
    step();
    chk("R1 grant after reset", 32'(p_grant), 0);
    chk("R1 seg after reset", 32'(seg_active), 0);
    chk("R1 src after reset", 32'(m_src), 0);

    // R2 R3 R8 sweep: every pair, every single fault
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        for (int f = 0; f < 5; f++) begin
          logic [3:0] prim, rt;
          bit alt;
          fault_seg = (f < 4) ? 4'(1 << f) : 4'b0;
          prim = exp_route(s, d, 0);
          alt  = (prim & fault_seg) != 0;
          rt   = alt ? exp_route(s, d, 1) : prim;
          req(s, d);
          step();
          chk("R2 grant", 32'(p_grant), 32'(1 << s));
          chk("R8 route", 32'(seg_active), 32'(rt));
          chk("R8 dir", 32'(seg_dir), alt ? 32'(rt) : 0);
          chk("R8 alt flag", 32'(p_alt), alt ? 32'(1 << s) : 0);
          chk("R3 busy", 32'(m_busy), 32'(1 << d));
          chk("R3 src", 32'(m_src), 32'(s << (2*d)));
          rel(s);
          chk("R9 released", 32'({p_grant, m_busy, seg_active}), 0);
        end
    fault_seg = '0;

    // R10 both routes faulted
    fault_seg = 4'b0101;
    req(0, 2); step(); step();
    chk("R10 blocked", 32'(p_grant), 0);
    fault_seg = 4'b0000; step();
    chk("R10 granted after clear", 32'(p_grant), 1);
    rel(0);

    // R4 memory port exclusive
    req(0, 1); step();
    req(2, 1); step(); step();
    chk("R4 waits", 32'(p_grant), 32'b0001);
    rel(0);
    chk("R4 not yet", 32'(p_grant), 0);
    step();
    chk("R4 granted", 32'(p_grant), 32'b0100);
    chk("R4 src", 32'(m_src), 32'(2 << 2));
    rel(2);

    // R5 shared segment with counting
    req(0, 2); req(1, 0); step();
    chk("R5 both granted", 32'(p_grant), 32'b0011);
    chk("R5 segs", 32'(seg_active), 32'b1111);
    chk("R5 dir", 32'(seg_dir), 0);
    rel(0);
    chk("R5 seg1 kept", 32'(seg_active), 32'b1110);
    rel(1);
    chk("R5 all idle", 32'(seg_active), 0);

    // R6 opposite direction conflict
    req(0, 2); step();
    fault_seg = 4'b1000;
    req(3, 1); step(); step();
    chk("R6 delayed", 32'(p_grant), 32'b0001);
    rel(0);
    chk("R6 still delayed", 32'(p_grant), 0);
    step();
    chk("R6 granted", 32'(p_grant), 32'b1000);
    chk("R6 alt", 32'(p_alt), 32'b1000);
    chk("R6 ccw segs", 32'(seg_dir), 32'b0110);
    rel(3);
    fault_seg = '0;

    // R7 priority
    req(1, 0); req(3, 0); step();
    chk("R7 lower wins", 32'(p_grant), 32'b0010);
    chk("R7 src", 32'(m_src), 1);
    rel(1);
    chk("R7 gap", 32'(p_grant), 0);
    step();
    chk("R7 next", 32'(p_grant), 32'b1000);
    rel(3);

    // R9 ignored inputs
    req(2, 3); step();
    p_done[0] = 1'b1;
    p_addr[2*AW +: AW] = {2'd0, 30'd9};
    step();
    p_done[0] = 1'b0;
    step();
    chk("R9 stray done ignored", 32'(p_grant), 32'b0100);
    chk("R9 addr change ignored", 32'(m_busy), 32'b1000);
    chk("R9 src kept", 32'(m_src), 32'h80);
    rel(2);
    chk("R9 release", 32'(m_busy), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule